// File: doc/BRIEF.md
# Five-Level Diode-Clamped Bridge Modulator

This block generates the gate pattern for a single-phase bridge made of two three-level diode-clamped legs. Each leg has four switches and three pole positions: upper rail, clamped midpoint and lower rail. Together the two legs give nine switching states and five output levels, which are written here as -2, -1, 0, +1 and +2 in units of half the DC-link voltage. The zero level has three redundant states. Each half level has two: one draws its current through the upper capacitor and the other through the lower capacitor. Each full level has a single state.

The block runs on a fixed sampling period. At each period boundary it captures a signed modulation index, the two capacitor voltages, the line-current sign, a mode select and a signed balancing offset. During the following period it works out the level pair, the active time and the share of the half-level time to give each redundant state. The share comes from a sequential divider. The resulting plan drives the legs for the whole period after that. Every state is placed in windows centred on the middle of the period.

In two-state mode the whole half-level time goes to one redundant state, chosen by a balancing rule. In three-state mode the half-level time is split between both redundant states. The split follows the measured capacitor voltages and is then shifted by the offset input.

Top module: `dcm_bridge_modulator`

## Requirements
- R1: Each leg's gate code is {outer-upper, inner-upper, inner-lower, outer-lower}. Upper rail is 4'b1100, midpoint is 4'b0110 and lower rail is 4'b0011. While reset is asserted, and through the first two periods, both legs sit at the midpoint.
- R2: A period lasts PERIOD_CYC clocks, and the period counter is 0 at reset release. Inputs present at the clock edge that ends period k govern the pattern of period k+2.
- R3: Let H = 2^(M_W-3). The magnitude |m| saturates at 2H. If |m| < H, the pair is zero/half. If |m| >= H, the pair is half/full. A negative index gives the mirrored states, with the two legs' poles swapped.
- R4: The active time is ta = floor(r*PERIOD_CYC/H), where r = |m| for the lower pair and r = |m| - H for the upper pair. A window of length L covers counts floor((PERIOD_CYC-L)/2) up to, but not including, that value plus L.
- R5: The zero level always uses both legs at the midpoint. The other two zero states are never produced.
- R6: In two-state mode the whole half-level time goes to one state. A current is "charging" when the line-current sign (1 = positive) XOR the index sign is 1. A charging current selects the upper-capacitor state if vcap_hi < vcap_lo. A discharging current selects it if vcap_hi > vcap_lo. In every other case, ties included, the lower-capacitor state is used.
- R7: In three-state mode both half states are used. For the lower pair, the upper-capacitor state fills a centred window of length tu, the lower-capacitor state fills the rest of the ta window, and zero fills the outside. For the upper pair, full fills the ta window, the upper-capacitor state fills the centred window of length ta+tu around it, and the lower-capacitor state fills the rest.
- R8: The share is f = floor(n*256/(vcap_hi+vcap_lo)), with n = vcap_lo for a charging current and n = vcap_hi for a discharging one. Then tu = floor(th*f/256), where th is the half-level time (ta for the lower pair, PERIOD_CYC-ta for the upper pair).
- R9: The balancing offset is added to f before use, and the sum is saturated to the range 0 to 256.
- R10: When both capacitor voltages are zero, f is 128 before the offset is added.
- R11: An index of magnitude 2H or more holds the full state for the entire period. An index of zero holds zero for the entire period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mod_idx | input | M_W | Signed modulation index, half level = 2^(M_W-3) |
| vcap_hi | input | V_W | Upper DC-link capacitor voltage |
| vcap_lo | input | V_W | Lower DC-link capacitor voltage |
| i_line_pos | input | 1 | Line-current sign, 1 = positive |
| three_state | input | 1 | 1 = split half time between both redundant states |
| bal_ofs | input | OFS_W | Signed correction added to the share (out of 256) |
| leg_a_gates | output | 4 | Gate code for leg A |
| leg_b_gates | output | 4 | Gate code for leg B |

## Verification
The period boundary is the cycle where three things coincide: the new input sample is captured, the divider's finished share is folded into the next plan, and that plan replaces the one driving the legs. The stimulus changes level pair, polarity, mode and capacitor balance from one period to the next. The bench's model then predicts every cycle, so a plan that loads one cycle early or late, or that mixes old and new operands, shows up as a mismatch in the first or last count of a period. Back-to-back periods of opposite sign, and periods with saturated offsets, make each edge compare a sharply different pattern against its predecessor.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [1:0] {
    POLE_N = 2'd0,
    POLE_O = 2'd1,
    POLE_P = 2'd2
  } pole_e;

  typedef enum logic [1:0] {
    ZONE_OUTER = 2'd0,
    ZONE_MID   = 2'd1,
    ZONE_INNER = 2'd2
  } zone_e;

  localparam logic [3:0] GATES_P = 4'b1100;
  localparam logic [3:0] GATES_O = 4'b0110;
  localparam logic [3:0] GATES_N = 4'b0011;

  function automatic logic [3:0] pole_to_gates(input pole_e p);
    case (p)
      POLE_P:  return GATES_P;
      POLE_N:  return GATES_N;
      default: return GATES_O;
    endcase
  endfunction

endpackage

// File: rtl/dcm_period_timer.sv
module dcm_period_timer #(
  parameter int PERIOD_CYC = 64,
  localparam int CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          first,
  output logic          last
);

  logic [CW-1:0] cnt_d, cnt_q;

  assign last  = (cnt_q == CW'(PERIOD_CYC - 1));
  assign first = (cnt_q == '0);
  assign cnt   = cnt_q;

  always_comb begin
    cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dcm_frac_divider.sv
module dcm_frac_divider #(
  parameter int NUM_W  = 13,
  parameter int FRAC_W = 8,
  localparam int SW = $clog2(FRAC_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             busy,
  output logic [FRAC_W:0]  quot
);

  logic [NUM_W:0]   rem_d, rem_q;
  logic [FRAC_W:0]  quot_d, quot_q;
  logic [SW-1:0]    steps_d, steps_q;
  logic             lead_d, lead_q;
  logic [NUM_W+1:0] trial;
  logic             fits;

  assign busy = (steps_q != '0);
  assign quot = quot_q;

  always_comb begin
    trial   = lead_q ? {1'b0, rem_q} : {rem_q, 1'b0};
    fits    = (trial >= {2'b00, den});
    rem_d   = rem_q;
    quot_d  = quot_q;
    steps_d = steps_q;
    lead_d  = lead_q;
    if (start) begin
      rem_d   = {1'b0, num};
      quot_d  = '0;
      steps_d = SW'(FRAC_W + 1);
      lead_d  = 1'b1;
    end else if (busy) begin
      rem_d   = fits ? (NUM_W+1)'(trial - {2'b00, den}) : trial[NUM_W:0];
      quot_d  = {quot_q[FRAC_W-1:0], fits};
      steps_d = steps_q - 1'b1;
      lead_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quot_q  <= '0;
      steps_q <= '0;
      lead_q  <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      quot_q  <= quot_d;
      steps_q <= steps_d;
      lead_q  <= lead_d;
    end
  end

  // R8: a finished share never exceeds one whole
  a_r8_share_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && den != '0) |-> (quot_q <= (FRAC_W+1)'(1 << FRAC_W)));

endmodule

// File: rtl/dcm_level_planner.sv
module dcm_level_planner #(
  parameter int PERIOD_CYC = 64,
  parameter int M_W        = 12,
  parameter int V_W        = 12,
  parameter int FRAC_W     = 8,
  parameter int OFS_W      = 9,
  localparam int TW = $clog2(PERIOD_CYC + 1)
) (
  input  logic signed [M_W-1:0]   m,
  input  logic        [V_W-1:0]   vu,
  input  logic        [V_W-1:0]   vl,
  input  logic                    cur_pos,
  input  logic                    three_mode,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic        [FRAC_W:0]  quot,
  output logic        [V_W:0]     div_num,
  output logic        [V_W:0]     div_den,
  output logic                    upper,
  output logic                    neg,
  output logic        [TW-1:0]    in_lo,
  output logic        [TW-1:0]    in_hi,
  output logic        [TW-1:0]    mid_lo,
  output logic        [TW-1:0]    mid_hi
);

  localparam int F    = M_W - 3;
  localparam int PW   = F + 1 + TW;
  localparam int QPW  = TW + FRAC_W + 1;
  localparam int SUMW = ((FRAC_W + 2) > OFS_W ? (FRAC_W + 2) : OFS_W) + 1;
  localparam logic [M_W:0]              HALF_M   = (M_W+1)'(1) << F;
  localparam logic [M_W:0]              FULL_M   = HALF_M << 1;
  localparam logic signed [SUMW-1:0]    FRAC_ONE = SUMW'(1) << FRAC_W;
  localparam logic [TW-1:0]             T_LEN    = TW'(PERIOD_CYC);

  logic signed [M_W:0]    m_ext;
  logic [M_W:0]           mag_raw, mag;
  logic [F:0]             rem;
  logic [PW-1:0]          prod;
  logic [TW-1:0]          ta, th, t_up, t_up3, len_in, len_mid;
  logic                   charging, sel_up;
  logic [FRAC_W:0]        frac_base, frac_sat;
  logic signed [SUMW-1:0] fsum;
  logic [QPW-1:0]         tprod;

  always_comb begin
    m_ext   = {m[M_W-1], m};
    neg     = m[M_W-1];
    mag_raw = neg ? (M_W+1)'(-m_ext) : (M_W+1)'(m_ext);
    mag     = (mag_raw > FULL_M) ? FULL_M : mag_raw;
    upper   = (mag >= HALF_M);
    rem     = upper ? (F+1)'(mag - HALF_M) : (F+1)'(mag);
    prod    = PW'(rem) * PW'(PERIOD_CYC);
    ta      = TW'(prod >> F);
    th      = upper ? (T_LEN - ta) : ta;

    charging = cur_pos ^ neg;
    sel_up   = charging ? (vu < vl) : (vu > vl);
    div_num  = {1'b0, (charging ? vl : vu)};
    div_den  = {1'b0, vu} + {1'b0, vl};

    frac_base = (div_den == '0) ? (FRAC_W+1)'(1 << (FRAC_W - 1)) : quot;
    fsum      = $signed(SUMW'(frac_base)) + SUMW'(ofs);
    if (fsum < 0)             frac_sat = '0;
    else if (fsum > FRAC_ONE) frac_sat = (FRAC_W+1)'(FRAC_ONE);
    else                      frac_sat = fsum[FRAC_W:0];
    tprod = QPW'(th) * QPW'(frac_sat);
    t_up3 = TW'(tprod >> FRAC_W);

    if (three_mode) t_up = t_up3;
    else            t_up = sel_up ? th : '0;

    len_in  = upper ? ta : t_up;
    len_mid = upper ? (ta + t_up) : ta;
    in_lo   = (T_LEN - len_in) >> 1;
    in_hi   = in_lo + len_in;
    mid_lo  = (T_LEN - len_mid) >> 1;
    mid_hi  = mid_lo + len_mid;
  end

endmodule

// File: rtl/dcm_pattern_decoder.sv
module dcm_pattern_decoder
  import dcm_pkg::*;
#(
  parameter int PERIOD_CYC = 64,
  localparam int CW = $clog2(PERIOD_CYC),
  localparam int TW = $clog2(PERIOD_CYC + 1)
) (
  input  logic [CW-1:0] cnt,
  input  logic          upper,
  input  logic          neg,
  input  logic [TW-1:0] in_lo,
  input  logic [TW-1:0] in_hi,
  input  logic [TW-1:0] mid_lo,
  input  logic [TW-1:0] mid_hi,
  output logic [3:0]    gates_a,
  output logic [3:0]    gates_b
);

  logic [TW-1:0] c;
  zone_e         zone;
  pole_e         pos_a, pos_b, pole_a, pole_b;

  always_comb begin
    c = TW'(cnt);
    if (c >= in_lo && c < in_hi)        zone = ZONE_INNER;
    else if (c >= mid_lo && c < mid_hi) zone = ZONE_MID;
    else                                zone = ZONE_OUTER;

    case (zone)
      ZONE_INNER: begin pos_a = POLE_P; pos_b = upper ? POLE_N : POLE_O; end
      ZONE_MID:   begin pos_a = upper ? POLE_P : POLE_O; pos_b = upper ? POLE_O : POLE_N; end
      default:    begin pos_a = POLE_O; pos_b = upper ? POLE_N : POLE_O; end
    endcase

    pole_a  = neg ? pos_b : pos_a;
    pole_b  = neg ? pos_a : pos_b;
    gates_a = pole_to_gates(pole_a);
    gates_b = pole_to_gates(pole_b);
  end

endmodule

// File: rtl/dcm_bridge_modulator.sv
module dcm_bridge_modulator
  import dcm_pkg::*;
#(
  parameter int PERIOD_CYC = 64,
  parameter int M_W        = 12,
  parameter int V_W        = 12,
  parameter int FRAC_W     = 8,
  parameter int OFS_W      = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [M_W-1:0]   mod_idx,
  input  logic        [V_W-1:0]   vcap_hi,
  input  logic        [V_W-1:0]   vcap_lo,
  input  logic                    i_line_pos,
  input  logic                    three_state,
  input  logic signed [OFS_W-1:0] bal_ofs,
  output logic        [3:0]       leg_a_gates,
  output logic        [3:0]       leg_b_gates
);

  localparam int CW = $clog2(PERIOD_CYC);
  localparam int TW = $clog2(PERIOD_CYC + 1);

  logic [CW-1:0] cnt;
  logic          first, last;

  // captured sample
  logic signed [M_W-1:0]   cap_m_d, cap_m_q;
  logic [V_W-1:0]          cap_vu_d, cap_vu_q, cap_vl_d, cap_vl_q;
  logic                    cap_cur_d, cap_cur_q, cap_mode_d, cap_mode_q;
  logic signed [OFS_W-1:0] cap_ofs_d, cap_ofs_q;

  // planner results and active plan
  logic [V_W:0]    div_num, div_den;
  logic [FRAC_W:0] div_quot;
  logic            div_busy;
  logic            pl_upper, pl_neg;
  logic [TW-1:0]   pl_in_lo, pl_in_hi, pl_mid_lo, pl_mid_hi;
  logic            act_upper_d, act_upper_q, act_neg_d, act_neg_q;
  logic [TW-1:0]   act_in_lo_d, act_in_lo_q, act_in_hi_d, act_in_hi_q;
  logic [TW-1:0]   act_mid_lo_d, act_mid_lo_q, act_mid_hi_d, act_mid_hi_q;

  dcm_period_timer #(.PERIOD_CYC(PERIOD_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .first(first), .last(last)
  );

  dcm_level_planner #(
    .PERIOD_CYC(PERIOD_CYC), .M_W(M_W), .V_W(V_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)
  ) i_planner (
    .m(cap_m_q), .vu(cap_vu_q), .vl(cap_vl_q), .cur_pos(cap_cur_q),
    .three_mode(cap_mode_q), .ofs(cap_ofs_q), .quot(div_quot),
    .div_num(div_num), .div_den(div_den), .upper(pl_upper), .neg(pl_neg),
    .in_lo(pl_in_lo), .in_hi(pl_in_hi), .mid_lo(pl_mid_lo), .mid_hi(pl_mid_hi)
  );

  dcm_frac_divider #(.NUM_W(V_W + 1), .FRAC_W(FRAC_W)) i_divider (
    .clk(clk), .rst_n(rst_n), .start(first), .num(div_num), .den(div_den),
    .busy(div_busy), .quot(div_quot)
  );

  dcm_pattern_decoder #(.PERIOD_CYC(PERIOD_CYC)) i_decoder (
    .cnt(cnt), .upper(act_upper_q), .neg(act_neg_q),
    .in_lo(act_in_lo_q), .in_hi(act_in_hi_q),
    .mid_lo(act_mid_lo_q), .mid_hi(act_mid_hi_q),
    .gates_a(leg_a_gates), .gates_b(leg_b_gates)
  );

  always_comb begin
    cap_m_d      = last ? mod_idx     : cap_m_q;
    cap_vu_d     = last ? vcap_hi     : cap_vu_q;
    cap_vl_d     = last ? vcap_lo     : cap_vl_q;
    cap_cur_d    = last ? i_line_pos  : cap_cur_q;
    cap_mode_d   = last ? three_state : cap_mode_q;
    cap_ofs_d    = last ? bal_ofs     : cap_ofs_q;
    act_upper_d  = last ? pl_upper    : act_upper_q;
    act_neg_d    = last ? pl_neg      : act_neg_q;
    act_in_lo_d  = last ? pl_in_lo    : act_in_lo_q;
    act_in_hi_d  = last ? pl_in_hi    : act_in_hi_q;
    act_mid_lo_d = last ? pl_mid_lo   : act_mid_lo_q;
    act_mid_hi_d = last ? pl_mid_hi   : act_mid_hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_m_q      <= '0;
      cap_vu_q     <= '0;
      cap_vl_q     <= '0;
      cap_cur_q    <= 1'b0;
      cap_mode_q   <= 1'b0;
      cap_ofs_q    <= '0;
      act_upper_q  <= 1'b0;
      act_neg_q    <= 1'b0;
      act_in_lo_q  <= '0;
      act_in_hi_q  <= '0;
      act_mid_lo_q <= '0;
      act_mid_hi_q <= '0;
    end else begin
      cap_m_q      <= cap_m_d;
      cap_vu_q     <= cap_vu_d;
      cap_vl_q     <= cap_vl_d;
      cap_cur_q    <= cap_cur_d;
      cap_mode_q   <= cap_mode_d;
      cap_ofs_q    <= cap_ofs_d;
      act_upper_q  <= act_upper_d;
      act_neg_q    <= act_neg_d;
      act_in_lo_q  <= act_in_lo_d;
      act_in_hi_q  <= act_in_hi_d;
      act_mid_lo_q <= act_mid_lo_d;
      act_mid_hi_q <= act_mid_hi_d;
    end
  end

  // output level polarity, decoded from the leg codes
  logic out_pos, out_neg;
  always_comb begin
    out_pos = (leg_a_gates == GATES_P && leg_b_gates != GATES_P) ||
              (leg_a_gates == GATES_O && leg_b_gates == GATES_N);
    out_neg = (leg_b_gates == GATES_P && leg_a_gates != GATES_P) ||
              (leg_b_gates == GATES_O && leg_a_gates == GATES_N);
  end

  // R1: every leg code is one of the three legal pole codes
  a_r1_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_a_gates == GATES_P) || (leg_a_gates == GATES_O) || (leg_a_gates == GATES_N)) &&
    ((leg_b_gates == GATES_P) || (leg_b_gates == GATES_O) || (leg_b_gates == GATES_N)));

  // R2: the share is ready before the boundary folds it into the plan
  a_r2_div_ready: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> !div_busy);

  // R3: no polarity reversal inside a period
  a_r3_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pos && !last) |=> !out_neg);
  a_r3_one_polarity_n: assert property (@(posedge clk) disable iff (!rst_n)
    (out_neg && !last) |=> !out_pos);

  // R11: a full-span window holds the full state on both legs
  a_r11_full_span: assert property (@(posedge clk) disable iff (!rst_n)
    (act_upper_q && act_in_lo_q == '0 && act_in_hi_q == TW'(PERIOD_CYC)) |->
    (act_neg_q ? (leg_a_gates == GATES_N && leg_b_gates == GATES_P)
               : (leg_a_gates == GATES_P && leg_b_gates == GATES_N)));

endmodule

// File: tb/test_dcm_bridge_modulator.sv
module test_dcm_bridge_modulator;

  localparam int T  = 64;
  localparam int H  = 512;
  localparam int NP = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [11:0] mod_idx;
  logic [11:0]       vcap_hi, vcap_lo;
  logic              i_line_pos, three_state;
  logic signed [8:0] bal_ofs;
  logic [3:0]        leg_a_gates, leg_b_gates;

  int s_m[NP], s_vu[NP], s_vl[NP], s_cur[NP], s_mode[NP], s_ofs[NP];
  string s_tag[NP];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dcm_bridge_modulator i_dcm_bridge_modulator (
    .clk(clk), .rst_n(rst_n), .mod_idx(mod_idx), .vcap_hi(vcap_hi),
    .vcap_lo(vcap_lo), .i_line_pos(i_line_pos), .three_state(three_state),
    .bal_ofs(bal_ofs), .leg_a_gates(leg_a_gates), .leg_b_gates(leg_b_gates)
  );

  task automatic put(input int i, input int m, input int vu, input int vl,
                     input int cur, input int mode, input int ofs, input string tag);
    s_m[i] = m; s_vu[i] = vu; s_vl[i] = vl; s_cur[i] = cur;
    s_mode[i] = mode; s_ofs[i] = ofs; s_tag[i] = tag;
  endtask

  task automatic apply(input int i);
    if (i < NP) begin
      mod_idx = 12'(s_m[i]); vcap_hi = 12'(s_vu[i]); vcap_lo = 12'(s_vl[i]);
      i_line_pos = s_cur[i][0]; three_state = s_mode[i][0]; bal_ofs = 9'(s_ofs[i]);
    end else begin
      mod_idx = '0; vcap_hi = '0; vcap_lo = '0;
      i_line_pos = 1'b0; three_state = 1'b0; bal_ofs = '0;
    end
  endtask

  function automatic logic [3:0] code(input int p);
    if (p == 2) return 4'b1100;
    if (p == 0) return 4'b0011;
    return 4'b0110;
  endfunction

  function automatic bit inwin(input int c, input int len);
    int lo;
    lo = (T - len) / 2;
    return (c >= lo) && (c < lo + len);
  endfunction

  // behavioural expectation for sample q at count c: {leg_a, leg_b}
  function automatic logic [7:0] expect_gates(input int q, input int c);
    int m, vu, vl, cur, mode, ofs;
    int ng, mag, up, r, ta, th, chg, tu, frac, den, pa, pb, t;
    if (q < 0 || q >= NP) begin m = 0; vu = 0; vl = 0; cur = 0; mode = 0; ofs = 0; end
    else begin m = s_m[q]; vu = s_vu[q]; vl = s_vl[q]; cur = s_cur[q]; mode = s_mode[q]; ofs = s_ofs[q]; end
    ng  = (m < 0) ? 1 : 0;
    mag = ng ? -m : m;
    if (mag > 2 * H) mag = 2 * H;
    up  = (mag >= H) ? 1 : 0;
    r   = up ? mag - H : mag;
    ta  = r * T / H;
    th  = up ? T - ta : ta;
    chg = cur ^ ng;
    if (mode != 0) begin
      den = vu + vl;
      frac = (den == 0) ? 128 : ((chg ? vl : vu) * 256) / den;
      frac = frac + ofs;
      if (frac < 0) frac = 0;
      if (frac > 256) frac = 256;
      tu = th * frac / 256;
    end else begin
      tu = ((chg && vu < vl) || (!chg && vu > vl)) ? th : 0;
    end
    if (up) begin
      if (inwin(c, ta))           begin pa = 2; pb = 0; end
      else if (inwin(c, ta + tu)) begin pa = 2; pb = 1; end
      else                        begin pa = 1; pb = 0; end
    end else begin
      if (inwin(c, tu))           begin pa = 2; pb = 1; end
      else if (inwin(c, ta))      begin pa = 1; pb = 0; end
      else                        begin pa = 1; pb = 1; end
    end
    if (ng) begin t = pa; pa = pb; pb = t; end
    return {code(pa), code(pb)};
  endfunction

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    logic [7:0] e;
    int p, c;
    string tg;
    if (!finished) begin
      if (!rst_n) begin
        checks++;
        if (leg_a_gates !== 4'b0110 || leg_b_gates !== 4'b0110) begin
          errors++;
          $display("FAIL R1 reset: a=%b b=%b expected a=0110 b=0110", leg_a_gates, leg_b_gates);
        end
      end else begin
        cyc++;
        p  = cyc / T;
        c  = cyc % T;
        e  = expect_gates(p - 2, c);
        tg = (p < 2) ? "R2" : ((p - 2 < NP) ? s_tag[p - 2] : "R11");
        checks++;
        if (leg_a_gates !== e[7:4] || leg_b_gates !== e[3:0]) begin
          errors++;
          $display("FAIL %s period %0d count %0d: a=%b b=%b expected a=%b b=%b",
                   tg, p, c, leg_a_gates, leg_b_gates, e[7:4], e[3:0]);
        end
      end
    end
  end

  initial begin
    // sample 0 lands in period 2; periods 0 and 1 must stay at zero (R2)
    put(0,   256, 1000, 1200, 1, 0,    0, "R6");   // charging, vu<vl: upper-cap state
    put(1,   256, 1200, 1000, 1, 0,    0, "R6");   // charging, vu>vl: lower-cap state
    put(2,  -300, 1200, 1000, 1, 0,    0, "R3");   // mirrored, discharging
    put(3,   700, 1000, 1000, 0, 0,    0, "R4");   // upper pair, tie -> lower-cap
    put(4,  1024, 1000, 1000, 1, 0,    0, "R11");  // full for whole period
    put(5,  2000,  900, 1100, 1, 1,    0, "R3");   // saturation
    put(6, -1024,  900, 1100, 0, 0,    0, "R11");  // negative full
    put(7,   400, 1000, 1000, 1, 1,    0, "R7");   // split, equal caps
    put(8,   400,  600, 1400, 1, 1,    0, "R8");   // charging share from vcap_lo
    put(9,   400,  600, 1400, 0, 1,    0, "R8");   // discharging share from vcap_hi
    put(10,  800,  900, 1100, 1, 1,    0, "R7");   // upper pair split
    put(11, -800,  900, 1100, 0, 1,    0, "R8");   // negative, charging
    put(12,  400, 1000, 1000, 1, 1,  200, "R9");   // offset saturates high
    put(13,  400, 1000, 1000, 1, 1, -200, "R9");   // offset saturates low
    put(14,  800,  700, 1300, 0, 1,   20, "R9");   // small offset
    put(15,  300,    0,    0, 1, 1,    0, "R10");  // zero voltages
    put(16, -700,    0,    0, 0, 1,  -30, "R10");
    put(17,    0, 1000, 1200, 1, 1,    0, "R5");   // zero level
    put(18,  511, 1000, 1200, 1, 0,    0, "R4");   // edge of lower pair
    put(19,  512, 1000, 1200, 1, 1,    0, "R3");   // start of upper pair
    put(20,-2048, 1200, 1000, 1, 1,   50, "R3");   // most negative index
    put(21,    0,    0,    0, 0, 0,    0, "R11");  // zero whole period
    put(22,  -60, 1100, 1000, 1, 1,   10, "R7");   // small negative split
    put(23,  100, 1000, 1100, 0, 0,    0, "R6");
    apply(0);
    repeat (3) @(negedge clk);
    #5 rst_n = 1'b1;
    for (int p = 1; p < NP + 3; p++) begin
      repeat (T) @(posedge clk);
      #5 apply(p);
    end
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule